// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

A bank of up to 32 general-purpose lines, driven through a 32-bit register interface with separate read and write strobes and a byte address. Each line can work in one of three ways: as an input that software samples, as an output that the block drives, or as an interrupt source. An interrupt source can be set to respond to a high level, a low level, a rising edge, a falling edge, or any transition. Every pin passes through a two-flop synchroniser before it is used.

Detected events are held in a status register. That register is gated by an enable mask, and the result drives a single combined interrupt request. Software enables lines by writing ones to one address and disables them by writing zeros to another address, so it never needs a read-modify-write. Pins are not driven as true inout ports. Instead the block supplies a per-line output value and output-enable for the pad ring to use. A noise-filter enable register is present but only stores its value.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, every `pinOe` bit is 0 and `irqOut` is 0. A line is therefore a masked general input.
- R2: `pinOe[i]` is 1 only when the mode bit (offset 0x00, 1 = interrupt) is 0 and the direction bit (offset 0x04, 1 = output) is 1. `pinOut[i]` equals the output-data bit (offset 0x08) on driven lines and 0 elsewhere.
- R3: Offset 0x0C reads the synchronised pin value XOR the polarity register (offset 0x20). A pin change becomes visible two clock edges later.
- R4: A write to offset 0x1C ORs the written bits into the enable mask. A write to offset 0x18 ANDs the mask with the written value. Offset 0x18 reads the mask, where 1 = enabled. Offsets 0x14 and 0x1C read as 0.
- R5: In edge mode (offset 0x24 bit = 1) with the both-edge bit at 0, polarity 0 latches the status bit (offset 0x10) on a rising transition and polarity 1 latches it on a falling one. The status bit is set three clock edges after the pin change. A line whose mode bit is 0 never latches status.
- R6: Writing 1 to a bit of offset 0x14 clears that latched edge status bit. Writing 0 leaves it unchanged.
- R7: When the both-edge bit (offset 0x4C) is 1 in edge mode, either transition latches status, whatever the polarity.
- R8: In level mode (offset 0x24 bit = 0) the status bit follows the active level, which is pin XOR polarity. A clear write does not remove it while that level persists.
- R9: `irqOut` is 1 exactly when some line has both its status bit and its mask bit set.
- R10: When an edge event and a clear write to the same line fall in the same cycle, the event wins and the status bit stays 1.
- R11: Mode, direction, output data, polarity, edge select, filter (offset 0x28) and both-edge registers read back as written. Accesses whose address has bits [1:0] nonzero are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte address of the register |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data, combinational, 0 when rdEn is low |
| pinIn | input | NUM_LINES (32) | Pad input values |
| pinOut | output | NUM_LINES (32) | Pad output values |
| pinOe | output | NUM_LINES (32) | Pad output enables |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge at which a new edge event is latched. From the ports this means placing the write exactly three edges after the pin toggles. The bench first latches a both-edge line, then toggles its pin and issues the clear write two falling edges later, so that the write is sampled on the edge where the synchronised sample and the previous sample differ. Level-low sensing is reached by arming a line whose pin is already low, so its status appears without any transition.

// File: rtl/gib_pkg.sv
package gib_pkg;

  // word index of each register (byte offset / 4)
  localparam int unsigned WIDX_MODE  = 0;
  localparam int unsigned WIDX_DIR   = 1;
  localparam int unsigned WIDX_OUT   = 2;
  localparam int unsigned WIDX_IN    = 3;
  localparam int unsigned WIDX_STAT  = 4;
  localparam int unsigned WIDX_CLR   = 5;
  localparam int unsigned WIDX_MASK  = 6;
  localparam int unsigned WIDX_MSET  = 7;
  localparam int unsigned WIDX_POL   = 8;
  localparam int unsigned WIDX_EDGE  = 9;
  localparam int unsigned WIDX_FILT  = 10;
  localparam int unsigned WIDX_BOTH  = 19;

  typedef enum logic [3:0] {
    RD_NONE, RD_MODE, RD_DIR, RD_OUT, RD_IN, RD_STAT,
    RD_MASK, RD_POL, RD_EDGE, RD_FILT, RD_BOTH
  } gibRdSel_t;

  typedef struct packed {
    logic wrMode;
    logic wrDir;
    logic wrOut;
    logic wrPol;
    logic wrEdge;
    logic wrFilt;
    logic wrBoth;
    logic wrMaskAnd;
    logic wrMaskOr;
    logic wrClr;
  } gibStrobe_t;

endpackage

// File: rtl/gib_ctrl.sv
module gib_ctrl
  import gib_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output gibStrobe_t        stb,
  output gibRdSel_t         rdSel
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  function automatic logic hit(input logic [WORD_W-1:0] idx, input int unsigned w);
    return idx == WORD_W'(w);
  endfunction

  always_comb begin
    stb = '0;
    if (wrEn && aligned) begin
      stb.wrMode    = hit(wordIdx, WIDX_MODE);
      stb.wrDir     = hit(wordIdx, WIDX_DIR);
      stb.wrOut     = hit(wordIdx, WIDX_OUT);
      stb.wrClr     = hit(wordIdx, WIDX_CLR);
      stb.wrMaskAnd = hit(wordIdx, WIDX_MASK);
      stb.wrMaskOr  = hit(wordIdx, WIDX_MSET);
      stb.wrPol     = hit(wordIdx, WIDX_POL);
      stb.wrEdge    = hit(wordIdx, WIDX_EDGE);
      stb.wrFilt    = hit(wordIdx, WIDX_FILT);
      stb.wrBoth    = hit(wordIdx, WIDX_BOTH);
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdEn && aligned) begin
      if      (hit(wordIdx, WIDX_MODE)) rdSel = RD_MODE;
      else if (hit(wordIdx, WIDX_DIR))  rdSel = RD_DIR;
      else if (hit(wordIdx, WIDX_OUT))  rdSel = RD_OUT;
      else if (hit(wordIdx, WIDX_IN))   rdSel = RD_IN;
      else if (hit(wordIdx, WIDX_STAT)) rdSel = RD_STAT;
      else if (hit(wordIdx, WIDX_MASK)) rdSel = RD_MASK;
      else if (hit(wordIdx, WIDX_POL))  rdSel = RD_POL;
      else if (hit(wordIdx, WIDX_EDGE)) rdSel = RD_EDGE;
      else if (hit(wordIdx, WIDX_FILT)) rdSel = RD_FILT;
      else if (hit(wordIdx, WIDX_BOTH)) rdSel = RD_BOTH;
    end
  end

  // R11: at most one register is written per cycle
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

endmodule

// File: rtl/gib_datapath.sv
module gib_datapath
  import gib_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  gibStrobe_t           stb,
  input  gibRdSel_t            rdSel,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] lineWr;
  logic [NUM_LINES-1:0] modeReg, dirReg, outReg, polReg, edgeReg, filtReg, bothReg;
  logic [NUM_LINES-1:0] maskReg, statReg, statNext;
  logic [NUM_LINES-1:0] syncA, syncB, prevS;
  logic [NUM_LINES-1:0] activeVec, riseVec, fallVec, evtVec;

  assign lineWr = wrData[NUM_LINES-1:0];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeReg <= '0;
      dirReg  <= '0;
      outReg  <= '0;
      polReg  <= '0;
      edgeReg <= '0;
      filtReg <= '0;
      bothReg <= '0;
    end else begin
      if (stb.wrMode) modeReg <= lineWr;
      if (stb.wrDir)  dirReg  <= lineWr;
      if (stb.wrOut)  outReg  <= lineWr;
      if (stb.wrPol)  polReg  <= lineWr;
      if (stb.wrEdge) edgeReg <= lineWr;
      if (stb.wrFilt) filtReg <= lineWr;
      if (stb.wrBoth) bothReg <= lineWr;
    end
  end

  // enable mask: AND-write disables, OR-write enables
  always_ff @(posedge clk) begin
    if (!rst_n)              maskReg <= '0;
    else if (stb.wrMaskAnd)  maskReg <= maskReg & lineWr;
    else if (stb.wrMaskOr)   maskReg <= maskReg | lineWr;
  end

  // two-flop synchroniser plus one history stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      prevS <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevS <= syncB;
    end
  end

  assign activeVec = syncB ^ polReg;
  assign riseVec   = syncB & ~prevS;
  assign fallVec   = ~syncB & prevS;

  // per-line event and status logic
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb begin
      if (bothReg[i])      evtVec[i] = riseVec[i] | fallVec[i];
      else if (polReg[i])  evtVec[i] = fallVec[i];
      else                 evtVec[i] = riseVec[i];

      if (!modeReg[i])       statNext[i] = 1'b0;
      else if (!edgeReg[i])  statNext[i] = activeVec[i];
      else                   statNext[i] = evtVec[i] | (statReg[i] & ~(stb.wrClr & lineWr[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) statReg <= '0;
    else        statReg <= statNext;
  end

  assign pinOe  = dirReg & ~modeReg;
  assign pinOut = outReg & pinOe;
  assign irqOut = |(statReg & maskReg);

  always_comb begin
    logic [NUM_LINES-1:0] sel;
    case (rdSel)
      RD_MODE: sel = modeReg;
      RD_DIR:  sel = dirReg;
      RD_OUT:  sel = outReg;
      RD_IN:   sel = activeVec;
      RD_STAT: sel = statReg;
      RD_MASK: sel = maskReg;
      RD_POL:  sel = polReg;
      RD_EDGE: sel = edgeReg;
      RD_FILT: sel = filtReg;
      RD_BOTH: sel = bothReg;
      default: sel = '0;
    endcase
    rdData = DATA_W'(sel);
  end

  // R4: an enable write leaves every written one enabled
  a_r4_mask_enable: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrMaskOr |=> ((maskReg & $past(lineWr)) == $past(lineWr)));

  // R6: a clear of an edge line with no new event removes the status
  a_r6_clear_edge: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrClr |=> ((statReg & $past(lineWr & modeReg & edgeReg & ~evtVec)) == '0));

  // R10: an event on an armed edge line always lands, clear or not
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statReg & $past(evtVec & modeReg & edgeReg)) == $past(evtVec & modeReg & edgeReg)));

  // R8: level lines mirror the previous cycle's active level
  a_r8_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((statReg ^ $past(activeVec)) & $past(modeReg & ~edgeReg)) == '0));

  // R2: a data write appears on every driven pin the next cycle
  a_r2_drive_data: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrOut |=> (((pinOut ^ $past(lineWr)) & pinOe) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gib_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqOut
);

  gibStrobe_t stb;
  gibRdSel_t  rdSel;

  gib_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .addr  (addr),
    .stb   (stb),
    .rdSel (rdSel)
  );

  gib_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );

  // R2: interrupt-mode lines are never driven
  a_r2_no_drive_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrMode |=> ((pinOe & $past(wrData[NUM_LINES-1:0])) == '0));

endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  always #2.5 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  typedef struct {
    int          sel;   // 0 rdData, 1 pinOe, 2 pinOut, 3 irqOut
    logic [31:0] exp;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];
  logic probe = 1'b0;
  int vectors = 0;
  int fails = 0;

  localparam logic [7:0] A_MODE = 8'h00, A_DIR = 8'h04, A_OUT = 8'h08, A_IN = 8'h0C,
                         A_STAT = 8'h10, A_CLR = 8'h14, A_MASK = 8'h18, A_MSET = 8'h1C,
                         A_POL = 8'h20, A_EDGE = 8'h24, A_FILT = 8'h28, A_BOTH = 8'h4C;

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectVal(input int sel, input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    if (sel == 0) begin rdEn = 1'b1; addr = a; end
    probe = 1'b1;
    @(negedge clk);
    probe = 1'b0; rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops expectations and compares against the design
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (probe) begin
        expItem_t it;
        logic [31:0] act;
        vectors++;
        if (sbQ.size() == 0) begin
          fails++;
          $display("FAIL scoreboard empty act=%h exp=none", rdData);
        end else begin
          it = sbQ.pop_front();
          case (it.sel)
            0: act = rdData;
            1: act = pinOe;
            2: act = pinOut;
            default: act = {31'b0, irqOut};
          endcase
          if (act !== it.exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectVal(0, A_MODE, 32'h0, "R1 mode");
    expectVal(0, A_DIR,  32'h0, "R1 dir");
    expectVal(0, A_STAT, 32'h0, "R1 status");
    expectVal(0, A_MASK, 32'h0, "R1 mask");
    expectVal(0, A_POL,  32'h0, "R1 polarity");
    expectVal(1, 8'h00,  32'h0, "R1 pinOe");
    expectVal(3, 8'h00,  32'h0, "R1 irqOut");

    // R2 output drive
    writeReg(A_OUT, 32'hA5A5_0F0F);
    writeReg(A_DIR, 32'hFFFF_0000);
    expectVal(1, 8'h00, 32'hFFFF_0000, "R2 oe by dir");
    expectVal(2, 8'h00, 32'hA5A5_0000, "R2 out on driven lines");
    writeReg(A_MODE, 32'h0F00_0000);
    expectVal(1, 8'h00, 32'hF0FF_0000, "R2 oe off in irq mode");
    expectVal(2, 8'h00, 32'hA0A5_0000, "R2 out off in irq mode");
    expectVal(0, A_OUT, 32'hA5A5_0F0F, "R11 out readback");
    writeReg(A_MODE, 32'h0);

    // R3 input data with polarity
    pinIn = 32'h1234_5678;
    settle();
    expectVal(0, A_IN, 32'h1234_5678, "R3 input plain");
    writeReg(A_POL, 32'hFFFF_0000);
    expectVal(0, A_IN, 32'hEDCB_5678, "R3 input inverted");
    pinIn = 32'h0;
    settle();

    // R4 mask writes
    writeReg(A_MSET, 32'h0000_00FF);
    writeReg(A_MSET, 32'h0000_0100);
    expectVal(0, A_MASK, 32'h0000_01FF, "R4 mask or");
    writeReg(A_MASK, 32'hFFFF_FFFD);
    expectVal(0, A_MASK, 32'h0000_01FD, "R4 mask and");
    writeReg(A_MASK, 32'h0);
    writeReg(A_MSET, 32'h0000_0017);
    expectVal(0, A_MSET, 32'h0, "R4 mask-set reads 0");
    expectVal(0, A_CLR,  32'h0, "R4 clear reads 0");

    // interrupt setup: l0 rise, l1 fall, l2 both, l4 level high
    writeReg(A_POL,  32'h0000_0006);
    writeReg(A_EDGE, 32'h0000_0007);
    writeReg(A_BOTH, 32'h0000_0004);
    writeReg(A_MODE, 32'h0000_0017);
    expectVal(0, A_STAT, 32'h0, "R5 no status on arming");
    expectVal(0, A_BOTH, 32'h4, "R11 both readback");

    // R5 rising, R9 irq
    pinIn[0] = 1'b1;
    settle();
    expectVal(0, A_STAT, 32'h1, "R5 rising latched");
    expectVal(3, 8'h00,  32'h1, "R9 irq on");
    // R6 clear
    writeReg(A_CLR, 32'h0);
    expectVal(0, A_STAT, 32'h1, "R6 zero write no effect");
    writeReg(A_CLR, 32'h1);
    expectVal(0, A_STAT, 32'h0, "R6 cleared");
    expectVal(3, 8'h00,  32'h0, "R9 irq off");

    // R5 falling
    pinIn[1] = 1'b1;
    settle();
    expectVal(0, A_STAT, 32'h0, "R5 falling line ignores rise");
    pinIn[1] = 1'b0;
    settle();
    expectVal(0, A_STAT, 32'h2, "R5 falling latched");
    writeReg(A_CLR, 32'h2);

    // R7 both edges
    pinIn[2] = 1'b1;
    settle();
    expectVal(0, A_STAT, 32'h4, "R7 rise on both-edge line");
    writeReg(A_CLR, 32'h4);
    expectVal(0, A_STAT, 32'h0, "R7 cleared");
    pinIn[2] = 1'b0;
    settle();
    expectVal(0, A_STAT, 32'h4, "R7 fall on both-edge line");

    // R10 clear and event in the same cycle
    pinIn[2] = 1'b1;
    repeat (2) @(negedge clk);
    writeReg(A_CLR, 32'h4);
    expectVal(0, A_STAT, 32'h4, "R10 event beats clear");
    writeReg(A_CLR, 32'h4);
    expectVal(0, A_STAT, 32'h0, "R10 later clear works");

    // R8 level high
    pinIn[4] = 1'b1;
    settle();
    expectVal(0, A_STAT, 32'h10, "R8 level high latched");
    writeReg(A_CLR, 32'h10);
    expectVal(0, A_STAT, 32'h10, "R8 clear ignored while active");
    pinIn[4] = 1'b0;
    settle();
    expectVal(0, A_STAT, 32'h0, "R8 level released");

    // R9 mask gating
    pinIn[0] = 1'b0;
    settle();
    writeReg(A_MASK, 32'hFFFF_FFFE);
    expectVal(0, A_MASK, 32'h16, "R4 disable single line");
    pinIn[0] = 1'b1;
    settle();
    expectVal(0, A_STAT, 32'h1, "R5 status while masked");
    expectVal(3, 8'h00,  32'h0, "R9 masked line no irq");
    writeReg(A_CLR, 32'h1);

    // R5 general-mode line never latches
    pinIn[8] = 1'b1;
    settle();
    expectVal(0, A_STAT, 32'h0, "R5 general line no status");
    pinIn[8] = 1'b0;

    // R8 level low on a pin already low
    writeReg(A_POL,  32'h0000_0026);
    writeReg(A_MODE, 32'h0000_0037);
    expectVal(0, A_STAT, 32'h20, "R8 level low latched");
    expectVal(3, 8'h00,  32'h0,  "R9 level low masked");
    writeReg(A_MSET, 32'h20);
    expectVal(3, 8'h00,  32'h1,  "R9 level low enabled");
    pinIn[5] = 1'b1;
    settle();
    expectVal(0, A_STAT, 32'h0, "R8 level low released");
    expectVal(3, 8'h00,  32'h0, "R9 irq drops");

    // R11 filter readback and misaligned access
    writeReg(A_FILT, 32'hDEAD_BEEF);
    expectVal(0, A_FILT, 32'hDEAD_BEEF, "R11 filter readback");
    writeReg(8'h29, 32'h0);
    expectVal(0, A_FILT, 32'hDEAD_BEEF, "R11 misaligned write ignored");
    expectVal(0, 8'h2A,  32'h0, "R11 misaligned read zero");
    expectVal(0, A_EDGE, 32'h7, "R11 edge readback");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule